// File: doc/BRIEF.md
# Delayed Write-Back Conflict Detector

This block watches a wide-issue core's register write port schedule. Every cycle the core issues a packet of up to eight destination writes, each carrying a register number, a valid bit and a two-bit latency class. The latency class is the number of cycles between issue and the actual write-back. A single-cycle operation writes in its issue cycle (class 0). A multiply has one delay slot and writes one cycle later (class 1). Classes 2 and 3 cover slower operations.

The detector keeps a short queue of pending writes, one slot for each future cycle. In every cycle it merges the writes that land in that cycle: pending ones that have come due, plus new class-0 writes. It raises `conflict_o` whenever one register receives two or more writes in the same landing cycle. `conflict_reg_o` names the lowest-numbered register involved. Conflicts are judged by landing cycle, not issue cycle. Two writes in one packet with different classes therefore never clash, while writes from consecutive packets can.

A flush drops every pending write and the packet presented with it.

Top module: `wb_conflict_det`

## Requirements
- R1: While `rst_ni` is low and after it rises, `conflict_o` is 0 and `conflict_reg_o` is 0, and no write issued before the reset ever lands afterwards.
- R2: Two valid class-0 writes to the same register in one packet raise `conflict_o` in that same cycle, with that register reported.
- R3: A class-0 and a class-1 write to the same register in one packet raise no conflict in the issue cycle or the following cycle.
- R4: A class-1 write issued in cycle t and a class-0 write to the same register issued in cycle t+1 raise `conflict_o` in cycle t+1.
- R5: A write of class L (the value 0 to 3 on `wr_lat_i`) lands exactly L cycles after issue. A class-3 write issued in cycle t clashes with a class-0 write to the same register issued in cycle t+3.
- R6: Two writes of equal nonzero class L to one register in one packet raise `conflict_o` L cycles after issue and not earlier.
- R7: Writes to distinct registers never raise a conflict, whatever their lane.
- R8: A lane whose `wr_valid_i` bit is 0 has no effect.
- R9: When several registers conflict in one cycle, `conflict_reg_o` gives the lowest register number. With no conflict it is 0.
- R10: In a cycle with `flush_i` high, `conflict_o` is 0, the packet in that cycle is discarded, and every pending write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Drops pending writes and the current packet |
| wr_valid_i | input | LANES | Per-lane write valid |
| wr_reg_i | input | LANES x REG_W | Per-lane destination register |
| wr_lat_i | input | LANES x LAT_W | Per-lane latency class (write lands this many cycles after issue) |
| conflict_o | output | 1 | Some register is written more than once in this cycle |
| conflict_reg_o | output | REG_W | Lowest conflicting register, 0 when none |

## Verification
The outputs are combinational from the current packet and the registered queue. A clash that involves a class-0 write therefore shows up in the issue cycle itself, and a clash between class-L writes shows up exactly L clock edges after issue. The bench applies each packet just after a falling edge and samples both outputs two nanoseconds later, before the next rising edge. Each table row therefore carries the result expected in its own cycle. Delayed clashes are checked by walking the idle or follow-up rows in between, so that a result arriving one cycle early or late is caught on those rows.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int LANES_DEF    = 8;
  localparam int NUM_REGS_DEF = 32;
  localparam int LAT_W_DEF    = 2;

  typedef enum logic [LAT_W_DEF-1:0] {
    LAT_NOW   = 2'd0,
    LAT_ONE   = 2'd1,
    LAT_TWO   = 2'd2,
    LAT_THREE = 2'd3
  } lat_class_e;
endpackage

// File: rtl/wbc_decode.sv
// Splits an issue packet into per-latency register masks plus duplicate masks.
module wbc_decode #(
  parameter int LANES    = 8,
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int LAT_W    = 2,
  localparam int DEPTH   = 1 << LAT_W
) (
  input  logic [LANES-1:0]                 valid_i,
  input  logic [LANES-1:0][REG_W-1:0]      reg_i,
  input  logic [LANES-1:0][LAT_W-1:0]      lat_i,
  output logic [DEPTH-1:0][NUM_REGS-1:0]   mask_o,
  output logic [DEPTH-1:0][NUM_REGS-1:0]   dup_o
);
  for (genvar d = 0; d < DEPTH; d++) begin : g_lat
    always_comb begin
      logic [NUM_REGS-1:0] hot;
      mask_o[d] = '0;
      dup_o[d]  = '0;
      for (int l = 0; l < LANES; l++) begin
        hot = '0;
        if (valid_i[l] && (lat_i[l] == LAT_W'(d))) hot[reg_i[l]] = 1'b1;
        dup_o[d]  = dup_o[d] | (mask_o[d] & hot);
        mask_o[d] = mask_o[d] | hot;
      end
    end
  end
endmodule

// File: rtl/wbc_pending.sv
// Queue of future write-backs; slot j holds writes landing j+1 cycles ahead.
module wbc_pending #(
  parameter int NUM_REGS = 32,
  parameter int LAT_W    = 2,
  localparam int DEPTH   = 1 << LAT_W,
  localparam int SLOTS   = DEPTH - 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic [DEPTH-1:0][NUM_REGS-1:0] new_mask_i,
  input  logic [DEPTH-1:0][NUM_REGS-1:0] new_dup_i,
  output logic [NUM_REGS-1:0]            land_dup_o
);
  logic [SLOTS-1:0][NUM_REGS-1:0] q_mask, q_dup, d_mask, d_dup;

  // writes landing now: due pending slot merged with fresh class-0 writes
  assign land_dup_o = q_dup[0] | new_dup_i[0] | (q_mask[0] & new_mask_i[0]);

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    if (j < SLOTS - 1) begin : g_mid
      assign d_mask[j] = q_mask[j+1] | new_mask_i[j+1];
      assign d_dup[j]  = q_dup[j+1] | new_dup_i[j+1] | (q_mask[j+1] & new_mask_i[j+1]);

      AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(flush_i) |-> (($past(q_mask[j+1]) & ~q_mask[j]) == '0)); // R5
    end else begin : g_top
      assign d_mask[j] = new_mask_i[j+1];
      assign d_dup[j]  = new_dup_i[j+1];
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flush_i) |-> (q_mask[j] == '0)); // R10

    AST_DUP_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_dup[j] & ~q_mask[j]) == '0); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_mask <= '0;
      q_dup  <= '0;
    end else if (flush_i) begin
      q_mask <= '0;
      q_dup  <= '0;
    end else begin
      q_mask <= d_mask;
      q_dup  <= d_dup;
    end
  end
endmodule

// File: rtl/wbc_prio.sv
// Lowest-index set bit finder.
module wbc_prio #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5
) (
  input  logic [NUM_REGS-1:0] req_i,
  output logic                any_o,
  output logic [REG_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = REG_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/wb_conflict_det.sv
module wb_conflict_det #(
  parameter int LANES    = wbc_pkg::LANES_DEF,
  parameter int NUM_REGS = wbc_pkg::NUM_REGS_DEF,
  parameter int LAT_W    = wbc_pkg::LAT_W_DEF,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int DEPTH   = 1 << LAT_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [LANES-1:0]              wr_valid_i,
  input  logic [LANES-1:0][REG_W-1:0]   wr_reg_i,
  input  logic [LANES-1:0][LAT_W-1:0]   wr_lat_i,
  output logic                          conflict_o,
  output logic [REG_W-1:0]              conflict_reg_o
);
  logic [DEPTH-1:0][NUM_REGS-1:0] pkt_mask, pkt_dup;
  logic [NUM_REGS-1:0]            land_dup, clash;
  logic [LANES-1:0]               lane_en;

  // a flushed packet never enters the queue
  assign lane_en = flush_i ? '0 : wr_valid_i;

  wbc_decode #(
    .LANES(LANES), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .LAT_W(LAT_W)
  ) u_decode (
    .valid_i (lane_en),
    .reg_i   (wr_reg_i),
    .lat_i   (wr_lat_i),
    .mask_o  (pkt_mask),
    .dup_o   (pkt_dup)
  );

  wbc_pending #(
    .NUM_REGS(NUM_REGS), .LAT_W(LAT_W)
  ) u_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .new_mask_i (pkt_mask),
    .new_dup_i  (pkt_dup),
    .land_dup_o (land_dup)
  );

  assign clash = flush_i ? '0 : land_dup;

  wbc_prio #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) u_prio (
    .req_i (clash),
    .any_o (conflict_o),
    .idx_o (conflict_reg_o)
  );

  AST_LANE_PAIR_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && wr_valid_i[0] && wr_valid_i[1] && wr_lat_i[0] == '0 &&
     wr_lat_i[1] == '0 && wr_reg_i[0] == wr_reg_i[1]) |-> conflict_o); // R2

  AST_REPORTED_IS_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> land_dup[conflict_reg_o]); // R9

  AST_REPORTED_IS_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> ((land_dup & ((NUM_REGS'(1) << conflict_reg_o) - NUM_REGS'(1))) == '0)); // R9
endmodule

// File: tb/wb_conflict_det_tb_top.sv
module wb_conflict_det_tb_top;
  localparam int LANES = 8;
  localparam int REG_W = 5;
  localparam int LAT_W = 2;

  typedef struct packed {
    logic             v;
    logic [REG_W-1:0] r;
    logic [LAT_W-1:0] l;
  } lane_t;

  typedef struct packed {
    logic             fl;
    lane_t            a;
    lane_t            b;
    lane_t            c;
    logic             ec;
    logic [REG_W-1:0] er;
  } vec_t;

  function automatic lane_t w(input int r, input int l);
    w = '{1'b1, REG_W'(r), LAT_W'(l)};
  endfunction

  localparam lane_t NO = '0;
  localparam int NVEC = 27;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, NO,      NO,      NO,      1'b0, 5'd0 },  // 0  R1 idle
    '{1'b0, w(5,0),  w(5,0),  NO,      1'b1, 5'd5 },  // 1  R2
    '{1'b0, w(2,1),  w(2,0),  NO,      1'b0, 5'd0 },  // 2  R3 issue
    '{1'b0, NO,      NO,      NO,      1'b0, 5'd0 },  // 3  R3 next
    '{1'b0, w(7,1),  NO,      NO,      1'b0, 5'd0 },  // 4  R4
    '{1'b0, w(7,0),  NO,      NO,      1'b1, 5'd7 },  // 5  R4 clash
    '{1'b0, w(9,3),  NO,      NO,      1'b0, 5'd0 },  // 6  R5
    '{1'b0, NO,      NO,      NO,      1'b0, 5'd0 },  // 7
    '{1'b0, NO,      NO,      NO,      1'b0, 5'd0 },  // 8
    '{1'b0, w(9,0),  NO,      NO,      1'b1, 5'd9 },  // 9  R5 clash
    '{1'b0, w(4,2),  w(4,2),  NO,      1'b0, 5'd0 },  // 10 R6
    '{1'b0, NO,      NO,      NO,      1'b0, 5'd0 },  // 11 R6 not early
    '{1'b0, NO,      NO,      NO,      1'b1, 5'd4 },  // 12 R6 lands
    '{1'b0, w(3,0),  w(6,0),  w(11,0), 1'b0, 5'd0 },  // 13 R7
    '{1'b0, '{1'b0,5'd8,2'd0}, w(8,0), NO, 1'b0, 5'd0 }, // 14 R8
    '{1'b0, w(10,1), NO,      NO,      1'b0, 5'd0 },  // 15 R9
    '{1'b0, w(12,0), w(10,0), w(12,0), 1'b1, 5'd10},  // 16 R9 lowest
    '{1'b0, w(20,1), w(20,1), NO,      1'b0, 5'd0 },  // 17 R9
    '{1'b0, w(15,0), w(15,0), NO,      1'b1, 5'd15},  // 18 R9 lowest
    '{1'b0, w(6,1),  NO,      NO,      1'b0, 5'd0 },  // 19 R10
    '{1'b1, w(6,0),  w(6,0),  NO,      1'b0, 5'd0 },  // 20 R10 silent
    '{1'b0, w(6,0),  NO,      NO,      1'b0, 5'd0 },  // 21 R10 cleared
    '{1'b0, w(6,2),  NO,      NO,      1'b0, 5'd0 },  // 22 R10
    '{1'b1, NO,      NO,      NO,      1'b0, 5'd0 },  // 23 R10 flush
    '{1'b0, w(6,0),  NO,      NO,      1'b0, 5'd0 },  // 24 R10 cleared
    '{1'b0, w(0,0),  w(0,0),  NO,      1'b1, 5'd0 },  // 25 R9 reg 0
    '{1'b0, w(31,0), w(31,0), w(31,0), 1'b1, 5'd31}   // 26 R2 triple
  };

  logic                        clk = 1'b0;
  logic                        rst_ni = 1'b0;
  logic                        flush_i = 1'b0;
  logic [LANES-1:0]            wr_valid_i = '0;
  logic [LANES-1:0][REG_W-1:0] wr_reg_i = '0;
  logic [LANES-1:0][LAT_W-1:0] wr_lat_i = '0;
  logic                        conflict_o;
  logic [REG_W-1:0]            conflict_reg_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  wb_conflict_det dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .wr_valid_i     (wr_valid_i),
    .wr_reg_i       (wr_reg_i),
    .wr_lat_i       (wr_lat_i),
    .conflict_o     (conflict_o),
    .conflict_reg_o (conflict_reg_o)
  );

  task automatic check(input string tag, input logic ec, input logic [REG_W-1:0] er);
    n_vec++;
    if (conflict_o !== ec || conflict_reg_o !== er) begin
      n_err++;
      $display("FAIL %s: conflict=%0b reg=%0d expected conflict=%0b reg=%0d",
               tag, conflict_o, conflict_reg_o, ec, er);
    end
  endtask

  task automatic clear_lanes();
    wr_valid_i = '0;
    wr_reg_i   = '0;
    wr_lat_i   = '0;
  endtask

  task automatic set_lane(input int k, input lane_t ln);
    wr_valid_i[k] = ln.v;
    wr_reg_i[k]   = ln.r;
    wr_lat_i[k]   = ln.l;
  endtask

  initial begin
    #3;
    check("R1 in reset", 1'b0, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      clear_lanes();
      flush_i = VECS[i].fl;
      set_lane(0, VECS[i].a);
      set_lane(1, VECS[i].b);
      set_lane(2, VECS[i].c);
      #2;
      check($sformatf("table row %0d", i), VECS[i].ec, VECS[i].er);
    end

    // R1: reset drops a pending write
    @(negedge clk);
    flush_i = 1'b0;
    clear_lanes();
    set_lane(0, w(13, 1));
    #2 check("R1 issue before reset", 1'b0, '0);
    @(negedge clk);
    clear_lanes();
    rst_ni = 1'b0;
    #2 check("R1 during reset", 1'b0, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    set_lane(0, w(13, 0));
    #2 check("R1 pending dropped by reset", 1'b0, '0);

    // R7: eight lanes, distinct registers
    @(negedge clk);
    clear_lanes();
    for (int k = 0; k < LANES; k++) set_lane(k, w(k + 16, 0));
    #2 check("R7 eight distinct", 1'b0, '0);

    // R5/R6: reg 1 at classes 0..3 once each, reg 2 twice at class 3 on high lanes
    @(negedge clk);
    clear_lanes();
    for (int k = 0; k < 4; k++) set_lane(k, w(1, k));
    set_lane(6, w(2, 3));
    set_lane(7, w(2, 3));
    #2 check("R5 mixed classes t+0", 1'b0, '0);
    @(negedge clk);
    clear_lanes();
    #2 check("R5 mixed classes t+1", 1'b0, '0);
    @(negedge clk);
    #2 check("R5 mixed classes t+2", 1'b0, '0);
    @(negedge clk);
    #2 check("R6 class-3 pair lands t+3", 1'b1, 5'd2);
    @(negedge clk);
    #2 check("R6 after landing", 1'b0, '0);

    // R8: all lanes invalid but naming one register
    @(negedge clk);
    for (int k = 0; k < LANES; k++) begin
      wr_reg_i[k] = 5'd3;
      wr_lat_i[k] = '0;
    end
    wr_valid_i = '0;
    #2 check("R8 invalid lanes", 1'b0, '0);
    @(negedge clk);
    clear_lanes();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule